// File: doc/BRIEF.md
# Abort Recovery State Recorder

This block keeps the small amount of state that a memory-management fault handler needs to undo or finish an operation that was cut short by an abort. While an instruction runs, the datapath reports each automatic increment or decrement it applies to a general register. The block packs up to two of these adjustments, each a signed delta with a register number, into one 16-bit log word. Alongside the log it holds an address word. During normal execution this is the address of the instruction that is running. During an interrupt or trap vector push it is the vector address being serviced.

When the translation unit raises its abort strobe, both words freeze. A completion flag records whether the abort struck inside a vector push, where the instruction had already finished, or inside an instruction, such as an instruction fetch. The words stay frozen until software clears the abort condition. Software reads them through a registered read port: the fault handler uses the log to roll registers back, and the address to re-run the instruction or to restart the vector flow.

Top module: `abort_recovery_recorder`

## Requirements
- R1: After synchronous reset the log word and the address word read 0x0000, the completion flag is 0 and capture is not frozen.
- R2: When not frozen, an instruction-start pulse loads the address word with the instruction PC and clears the log word.
- R3: When not frozen, a vector-start pulse loads the address word with the vector address and clears the log word. If both start pulses occur in the same cycle, the vector start wins.
- R4: Each log slot is one byte. Bits [7:3] hold the delta in 5-bit two's complement and bits [2:0] hold the register number. Examples: register 6 with delta -2 gives 0xF6, register 7 with +15 gives 0x7F, register 0 with -16 gives 0x80.
- R5: The first adjustment after a start goes to bits [7:0] and the second to bits [15:8]. Any further adjustments are dropped until the next start. An adjustment in the same cycle as a start is dropped.
- R6: The abort strobe freezes both words. Events in the abort cycle itself are still applied. Starts and adjustments that follow are ignored up to and including the cycle in which the release input is high. Capture resumes in the cycle after release.
- R7: On an abort that is accepted while not frozen, the completion flag becomes 1 if the most recent start before that cycle was a vector start, and 0 if it was an instruction start. The flag holds its value until the next accepted abort.
- R8: A read with select 0 returns the log word and a read with select 1 returns the address word. The data appears on the read data output one cycle after the read enable. Without a read, the output holds its value.
- R9: After a fetch abort the log is 0x0000 and the address is the faulting PC. After a vector-push abort with two stack-pointer decrements by 2, the log reads 0xF6F6 and the address is the vector address, for example 0x00A0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_start_i | input | 1 | Pulse: a new instruction begins |
| instr_pc_i | input | 16 | Address of the instruction that is starting |
| vec_start_i | input | 1 | Pulse: a vector flow begins |
| vec_addr_i | input | 16 | Vector address being serviced |
| adj_valid_i | input | 1 | A register auto-adjustment was applied |
| adj_reg_i | input | 3 | Register number of the adjustment |
| adj_delta_i | input | 5 | Signed delta of the adjustment |
| abort_i | input | 1 | Abort strobe from the translation unit |
| release_i | input | 1 | Abort condition cleared by software |
| rd_en_i | input | 1 | Read request |
| rd_sel_i | input | 1 | Read select: 0 log word, 1 address word |
| rd_data_o | output | 16 | Registered read data |
| cmpl_o | output | 1 | Instruction-complete flag of the last abort |

## Verification
The bench targets the corner cases of slot ordering and of the freeze window. A recorder that fills the slots in the wrong order returns 0x0AF6 where 0xF60A is expected. One that keeps logging past two adjustments corrupts the first slot. One that lets a start in the same cycle keep its adjustment shows a nonzero log after a start. The freeze window is probed at both edges: an adjustment in the abort cycle must appear in the log, while starts during the frozen period and events in the release cycle must not. It also checks that the completion flag tracks the flow type, and that the vector start wins when both starts arrive in one cycle.

// File: rtl/abrec_pkg.sv
`timescale 1ns/1ps
package abrec_pkg;
  typedef enum logic {FLOW_INSTR = 1'b0, FLOW_VECTOR = 1'b1} flow_e;
  localparam logic SEL_LOG  = 1'b0;
  localparam logic SEL_ADDR = 1'b1;
endpackage

// File: rtl/abrec_adj_log.sv
`timescale 1ns/1ps
module abrec_adj_log #(
  parameter int SLOTS   = 2,
  parameter int RNUM_W  = 3,
  parameter int DELTA_W = 5,
  localparam int SLOT_W = RNUM_W + DELTA_W,
  localparam int LOG_W  = SLOTS * SLOT_W,
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hold_i,
  input  logic               clear_i,
  input  logic               upd_i,
  input  logic [RNUM_W-1:0]  upd_num_i,
  input  logic [DELTA_W-1:0] upd_delta_i,
  output logic [LOG_W-1:0]   log_o
);
  logic [CNT_W-1:0] fill_q;

  // number of slots already used since the last start
  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
    end else if (!hold_i) begin
      if (clear_i) begin
        fill_q <= '0;
      end else if (upd_i && (fill_q < CNT_W'(SLOTS))) begin
        fill_q <= fill_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [SLOT_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '0;
      end else if (!hold_i) begin
        if (clear_i) begin
          slot_q <= '0;
        end else if (upd_i && (fill_q == CNT_W'(g))) begin
          slot_q <= {upd_delta_i, upd_num_i};
        end
      end
    end
    assign log_o[g*SLOT_W +: SLOT_W] = slot_q;
  end
endmodule

// File: rtl/abrec_addr_cap.sv
`timescale 1ns/1ps
module abrec_addr_cap
  import abrec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold_i,
  input  logic              instr_start_i,
  input  logic [ADDR_W-1:0] instr_pc_i,
  input  logic              vec_start_i,
  input  logic [ADDR_W-1:0] vec_addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output flow_e             flow_o
);
  logic [ADDR_W-1:0] addr_q;
  flow_e             flow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      flow_q <= FLOW_INSTR;
    end else if (!hold_i) begin
      if (vec_start_i) begin
        addr_q <= vec_addr_i;
        flow_q <= FLOW_VECTOR;
      end else if (instr_start_i) begin
        addr_q <= instr_pc_i;
        flow_q <= FLOW_INSTR;
      end
    end
  end

  assign addr_o = addr_q;
  assign flow_o = flow_q;
endmodule

// File: rtl/abrec_ctrl.sv
`timescale 1ns/1ps
module abrec_ctrl
  import abrec_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  abort_i,
  input  logic  release_i,
  input  flow_e flow_i,
  output logic  frozen_o,
  output logic  cmpl_o
);
  logic frozen_q;
  logic cmpl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frozen_q <= 1'b0;
      cmpl_q   <= 1'b0;
    end else if (frozen_q) begin
      if (release_i) frozen_q <= 1'b0;
    end else if (abort_i) begin
      frozen_q <= 1'b1;
      cmpl_q   <= (flow_i == FLOW_VECTOR);
    end
  end

  assign frozen_o = frozen_q;
  assign cmpl_o   = cmpl_q;
endmodule

// File: rtl/abrec_rd_port.sv
`timescale 1ns/1ps
module abrec_rd_port
  import abrec_pkg::*;
#(
  parameter int LOG_W  = 16,
  parameter int ADDR_W = 16,
  localparam int RD_W  = (LOG_W > ADDR_W) ? LOG_W : ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic              rd_sel_i,
  input  logic [LOG_W-1:0]  log_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [RD_W-1:0]   rd_data_o
);
  logic [RD_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (rd_en_i) begin
      data_q <= (rd_sel_i == SEL_ADDR) ? RD_W'(addr_i) : RD_W'(log_i);
    end
  end

  assign rd_data_o = data_q;
endmodule

// File: rtl/abort_recovery_recorder.sv
`timescale 1ns/1ps
module abort_recovery_recorder
  import abrec_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SLOTS   = 2,
  parameter int RNUM_W  = 3,
  parameter int DELTA_W = 5,
  localparam int LOG_W  = SLOTS * (RNUM_W + DELTA_W),
  localparam int RD_W   = (LOG_W > ADDR_W) ? LOG_W : ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_start_i,
  input  logic [ADDR_W-1:0]  instr_pc_i,
  input  logic               vec_start_i,
  input  logic [ADDR_W-1:0]  vec_addr_i,
  input  logic               adj_valid_i,
  input  logic [RNUM_W-1:0]  adj_reg_i,
  input  logic [DELTA_W-1:0] adj_delta_i,
  input  logic               abort_i,
  input  logic               release_i,
  input  logic               rd_en_i,
  input  logic               rd_sel_i,
  output logic [RD_W-1:0]    rd_data_o,
  output logic               cmpl_o
);
  logic              frozen_w;
  logic              start_w;
  flow_e             flow_w;
  logic [LOG_W-1:0]  log_w;
  logic [ADDR_W-1:0] addr_w;

  assign start_w = instr_start_i | vec_start_i;

  abrec_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .abort_i   (abort_i),
    .release_i (release_i),
    .flow_i    (flow_w),
    .frozen_o  (frozen_w),
    .cmpl_o    (cmpl_o)
  );

  abrec_adj_log #(.SLOTS(SLOTS), .RNUM_W(RNUM_W), .DELTA_W(DELTA_W)) log_i (
    .clk         (clk),
    .rst         (rst),
    .hold_i      (frozen_w),
    .clear_i     (start_w),
    .upd_i       (adj_valid_i),
    .upd_num_i   (adj_reg_i),
    .upd_delta_i (adj_delta_i),
    .log_o       (log_w)
  );

  abrec_addr_cap #(.ADDR_W(ADDR_W)) addr_i (
    .clk           (clk),
    .rst           (rst),
    .hold_i        (frozen_w),
    .instr_start_i (instr_start_i),
    .instr_pc_i    (instr_pc_i),
    .vec_start_i   (vec_start_i),
    .vec_addr_i    (vec_addr_i),
    .addr_o        (addr_w),
    .flow_o        (flow_w)
  );

  abrec_rd_port #(.LOG_W(LOG_W), .ADDR_W(ADDR_W)) rd_i (
    .clk       (clk),
    .rst       (rst),
    .rd_en_i   (rd_en_i),
    .rd_sel_i  (rd_sel_i),
    .log_i     (log_w),
    .addr_i    (addr_w),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/abrec_checker.sv
`timescale 1ns/1ps
module abrec_checker
  import abrec_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LOG_W  = 16,
  parameter int RD_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_start_i,
  input logic [ADDR_W-1:0] instr_pc_i,
  input logic              vec_start_i,
  input logic [ADDR_W-1:0] vec_addr_i,
  input logic              abort_i,
  input logic              release_i,
  input logic              rd_en_i,
  input logic              rd_sel_i,
  input logic [RD_W-1:0]   rd_data_o,
  input logic              cmpl_o,
  input logic              frozen_w,
  input flow_e             flow_w,
  input logic [LOG_W-1:0]  log_w,
  input logic [ADDR_W-1:0] addr_w
);
  assert_instr_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!frozen_w && instr_start_i && !vec_start_i) |=>
      (addr_w == $past(instr_pc_i)) && (log_w == '0));

  assert_vec_load_R3: assert property (@(posedge clk) disable iff (rst)
    (!frozen_w && vec_start_i) |=>
      (addr_w == $past(vec_addr_i)) && (log_w == '0) && (flow_w == FLOW_VECTOR));

  assert_frozen_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (frozen_w && !release_i) |=> frozen_w && $stable(log_w) && $stable(addr_w));

  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    (frozen_w && release_i) |=> !frozen_w);

  assert_abort_cmpl_R7: assert property (@(posedge clk) disable iff (rst)
    (!frozen_w && abort_i) |=>
      frozen_w && (cmpl_o == ($past(flow_w) == FLOW_VECTOR)));

  assert_cmpl_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !(!frozen_w && abort_i) |=> $stable(cmpl_o));

  assert_read_addr_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && rd_sel_i == SEL_ADDR) |=> rd_data_o == RD_W'($past(addr_w)));

  assert_read_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind abort_recovery_recorder abrec_checker #(
  .ADDR_W (ADDR_W),
  .LOG_W  (LOG_W),
  .RD_W   (RD_W)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .instr_start_i (instr_start_i),
  .instr_pc_i    (instr_pc_i),
  .vec_start_i   (vec_start_i),
  .vec_addr_i    (vec_addr_i),
  .abort_i       (abort_i),
  .release_i     (release_i),
  .rd_en_i       (rd_en_i),
  .rd_sel_i      (rd_sel_i),
  .rd_data_o     (rd_data_o),
  .cmpl_o        (cmpl_o),
  .frozen_w      (frozen_w),
  .flow_w        (flow_w),
  .log_w         (log_w),
  .addr_w        (addr_w)
);

// File: tb/abort_recovery_recorder_tb_top.sv
`timescale 1ns/1ps
module abort_recovery_recorder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_start = 1'b0;
  logic [15:0] instr_pc = '0;
  logic        vec_start = 1'b0;
  logic [15:0] vec_addr = '0;
  logic        adj_valid = 1'b0;
  logic [2:0]  adj_reg = '0;
  logic [4:0]  adj_delta = '0;
  logic        abort_s = 1'b0;
  logic        release_s = 1'b0;
  logic        rd_en = 1'b0;
  logic        rd_sel = 1'b0;
  logic [15:0] rd_data;
  logic        cmpl;

  int checks = 0;
  int errors = 0;
  logic rd_fire = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  abort_recovery_recorder dut_i (
    .clk(clk), .rst(rst),
    .instr_start_i(instr_start), .instr_pc_i(instr_pc),
    .vec_start_i(vec_start), .vec_addr_i(vec_addr),
    .adj_valid_i(adj_valid), .adj_reg_i(adj_reg), .adj_delta_i(adj_delta),
    .abort_i(abort_s), .release_i(release_s),
    .rd_en_i(rd_en), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .cmpl_o(cmpl)
  );

  // monitor: a read issued before an edge is compared at the next falling edge
  always @(posedge clk) rd_fire <= rd_en;

  always @(negedge clk) begin
    if (rd_fire) begin
      logic [15:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expected item, actual %h", rd_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: read data actual %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic cyc();
    @(negedge clk);
    instr_start = 0; vec_start = 0; adj_valid = 0;
    abort_s = 0; release_s = 0; rd_en = 0;
  endtask

  task automatic rd(input logic sel, input logic [15:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1; rd_sel = sel;
    cyc();
  endtask

  task automatic do_instr(input logic [15:0] pc);
    instr_start = 1; instr_pc = pc; cyc();
  endtask

  task automatic do_vec(input logic [15:0] a);
    vec_start = 1; vec_addr = a; cyc();
  endtask

  task automatic do_adj(input logic [2:0] r, input int d);
    adj_valid = 1; adj_reg = r; adj_delta = 5'(d); cyc();
  endtask

  task automatic chk_cmpl(input logic e, input string t);
    checks++;
    if (cmpl !== e) begin
      errors++;
      $display("FAIL %s: cmpl actual %b expected %b", t, cmpl, e);
    end
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(0, 16'h0000, "R1"); rd(1, 16'h0000, "R1"); chk_cmpl(0, "R1");
    // R2 R4 R5 slot fill and overflow
    do_instr(16'h0200);
    rd(1, 16'h0200, "R2"); rd(0, 16'h0000, "R2");
    do_adj(6, -2); rd(0, 16'h00F6, "R4");
    do_adj(6, -2); rd(0, 16'hF6F6, "R5");
    do_adj(3, 1);  rd(0, 16'hF6F6, "R5 third dropped");
    // R5 order with distinct slots
    do_instr(16'h0300); do_adj(2, 1); do_adj(6, -2);
    rd(0, 16'hF60A, "R5 order"); rd(1, 16'h0300, "R2");
    // R4 delta extremes
    do_instr(16'h0400); do_adj(7, 15); do_adj(0, -16);
    rd(0, 16'h807F, "R4 extremes");
    // R5 adjustment in start cycle dropped
    instr_start = 1; instr_pc = 16'h0500; adj_valid = 1; adj_reg = 1; adj_delta = 5'd1; cyc();
    rd(0, 16'h0000, "R5 start cycle");
    // R3 vector start clears log
    do_instr(16'h0600); do_adj(6, -2); do_vec(16'h00A0);
    rd(0, 16'h0000, "R3"); rd(1, 16'h00A0, "R3");
    // R3 both starts: vector wins
    instr_start = 1; instr_pc = 16'h0700; vec_start = 1; vec_addr = 16'h00A4; cyc();
    rd(1, 16'h00A4, "R3 priority");
    // R9 R7 fetch abort
    do_instr(16'h1234); abort_s = 1; cyc();
    rd(0, 16'h0000, "R9 fetch"); rd(1, 16'h1234, "R9 fetch"); chk_cmpl(0, "R7 fetch");
    // R6 frozen: events ignored
    do_instr(16'h5555); do_adj(6, -2); do_vec(16'h00B0);
    rd(1, 16'h1234, "R6 frozen"); rd(0, 16'h0000, "R6 frozen");
    release_s = 1; adj_valid = 1; adj_reg = 5; adj_delta = 5'd1; cyc();
    rd(0, 16'h0000, "R6 release cycle");
    do_instr(16'h2000); rd(1, 16'h2000, "R6 resumed");
    // R9 R7 vector push abort
    do_vec(16'h00A0); do_adj(6, -2); do_adj(6, -2); abort_s = 1; cyc();
    rd(0, 16'hF6F6, "R9 vector"); rd(1, 16'h00A0, "R9 vector"); chk_cmpl(1, "R7 vector");
    release_s = 1; cyc();
    // R6 adjustment in abort cycle is kept
    do_vec(16'h00A8); adj_valid = 1; adj_reg = 6; adj_delta = 5'(-2); abort_s = 1; cyc();
    rd(0, 16'h00F6, "R6 abort cycle"); chk_cmpl(1, "R7");
    release_s = 1; cyc();
    do_instr(16'h3000); abort_s = 1; cyc();
    chk_cmpl(0, "R7 back to instr");
    release_s = 1; cyc();
    // R8 data holds without read
    rd(1, 16'h3000, "R8");
    repeat (3) cyc();
    checks++;
    if (rd_data !== 16'h3000) begin
      errors++;
      $display("FAIL R8 hold: actual %h expected %h", rd_data, 16'h3000);
    end
    repeat (2) cyc();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule